// File: doc/BRIEF.md
# Radio Command Strobe Arbiter

This block sits between a command interface and the control logic of a packet radio. Each accepted command strobe is a single opcode byte. The block checks the opcode against the live radio status: whether the radio is idle, whether a frame is arriving, and whether automatic acknowledgement is on. It then either emits a one-cycle control pulse or raises a sticky exception flag instead. Some commands do both: they act, and they also report the frame they aborted.

Acknowledgement commands do not act at once. They record a decision for the frame now being received. The most recent decision wins. A frame-end input consumes the decision and produces the acknowledgement request. The oscillator, the FIFOs, the demodulator and the acknowledgement frame builder live elsewhere. Here they appear only as pulse outputs or status inputs.

All outputs are registered. A strobe sampled on a clock edge takes effect on the outputs right after that edge.

Top module: `radio_cmd_arbiter`

## Requirements
- R1: After reset, every pulse output, `ack_send`, `ack_pend_bit`, `usage_err` and `frame_aborted` are 0.
- R2: Opcode 0x01 (oscillator off) with `radio_idle`=1 gives a one-cycle `osc_off_pulse` in the cycle after the strobe, and no flag.
- R3: Opcode 0x01 with `radio_idle`=0 gives no `osc_off_pulse` and sets `usage_err`. If `frame_rx`=1 it also sets `frame_aborted`.
- R4: Opcode 0x02 (receive flush) always gives a one-cycle `flush_rx_pulse`. It also sets `frame_aborted` when `frame_rx`=1.
- R5: Opcode 0x03 (transmit flush) always gives a one-cycle `flush_tx_pulse` and sets no flag, even while a frame is arriving.
- R6: With `frame_rx`=1, opcode 0x04 (acknowledge) or 0x05 (acknowledge, pending set) is latched. The next `frame_end` then produces a one-cycle `ack_send`, with `ack_pend_bit` equal to 0 for 0x04 and 1 for 0x05. `ack_pend_bit` is 0 whenever `ack_send` is 0.
- R7: A later acknowledge-type strobe during the same frame replaces the earlier one. This holds for 0x04, 0x05 and 0x06.
- R8: Opcode 0x06 (no acknowledge) with `frame_rx`=1 gives a one-cycle `nack_pulse`. The following `frame_end` then produces no `ack_send`, even with `auto_ack_en`=1.
- R9: If no acknowledge-type strobe was accepted since the last `frame_end`, then `frame_end` produces `ack_send` with `ack_pend_bit`=0 when `auto_ack_en`=1, and nothing when `auto_ack_en`=0.
- R10: Opcodes 0x04, 0x05 and 0x06 with `frame_rx`=0 set `usage_err`. They give no `nack_pulse` and leave the pending acknowledgement decision unchanged.
- R11: `usage_err` and `frame_aborted` stay set until `exc_clear` is pulsed. A new exception in the same cycle as `exc_clear` leaves its flag set.
- R12: Any other opcode value is ignored. It gives no pulse, no flag, and no change to the acknowledgement decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_valid | input | 1 | Opcode is valid this cycle |
| opcode | input | 8 | Command strobe opcode |
| radio_idle | input | 1 | RF section is idle |
| frame_rx | input | 1 | A frame is currently being received |
| auto_ack_en | input | 1 | Automatic acknowledgement enabled |
| frame_end | input | 1 | The received frame has ended |
| exc_clear | input | 1 | Clears both exception flags |
| osc_off_pulse | output | 1 | Stop the crystal oscillator |
| flush_rx_pulse | output | 1 | Flush receive FIFO and reset demodulator |
| flush_tx_pulse | output | 1 | Flush transmit FIFO |
| nack_pulse | output | 1 | Acknowledgement suppressed for current frame |
| ack_send | output | 1 | Send an acknowledgement frame now |
| ack_pend_bit | output | 1 | Pending subfield for the acknowledgement |
| usage_err | output | 1 | Sticky usage-error flag |
| frame_aborted | output | 1 | Sticky frame-aborted flag |

## Verification
Each opcode is issued under several status combinations: idle, busy with no frame, and busy with a frame arriving. This separates the opcodes that refuse from the ones that act and also report. Acknowledgement checks use ordered pairs of strobes within one frame, which shows that the last decision wins and not the first. They also use frames with no strobe, with automatic acknowledgement on and off, and strobes issued with no frame present, which must leave the default decision unchanged. An unknown opcode during a busy frame, and a fault raised in the same cycle as the clear, cover the cases where nothing must change.

// File: rtl/radio_cmd_pkg.sv
package radio_cmd_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [CMD_W-1:0] {
    OP_OSC_OFF  = 8'h01,
    OP_FLUSH_RX = 8'h02,
    OP_FLUSH_TX = 8'h03,
    OP_ACK      = 8'h04,
    OP_ACK_PEND = 8'h05,
    OP_NO_ACK   = 8'h06
  } cmd_e;

  typedef struct packed {
    logic osc;
    logic frx;
    logic ftx;
    logic ack;
    logic ackp;
    logic nack;
  } cmd_hit_t;

  typedef enum logic [1:0] {
    ACKD_DEFAULT = 2'd0,
    ACKD_PLAIN   = 2'd1,
    ACKD_PEND    = 2'd2,
    ACKD_SUPPR   = 2'd3
  } ack_dec_e;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import radio_cmd_pkg::*;
(
  input  logic             valid,
  input  logic [CMD_W-1:0] opcode,
  output cmd_hit_t         hit
);

  always_comb begin
    hit = '0;
    if (valid) begin
      case (opcode)
        OP_OSC_OFF:  hit.osc  = 1'b1;
        OP_FLUSH_RX: hit.frx  = 1'b1;
        OP_FLUSH_TX: hit.ftx  = 1'b1;
        OP_ACK:      hit.ack  = 1'b1;
        OP_ACK_PEND: hit.ackp = 1'b1;
        OP_NO_ACK:   hit.nack = 1'b1;
        default:     hit = '0;
      endcase
    end
  end

endmodule

// File: rtl/ack_sched.sv
module ack_sched
  import radio_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic auto_ack_en,
  input  logic set_plain,
  input  logic set_pend,
  input  logic set_suppr,
  output logic ack_send,
  output logic ack_pend_bit
);

  ack_dec_e dec_q, dec_d;
  logic     send_d, pend_d;

  always_comb begin
    dec_d = dec_q;
    if (frame_end)      dec_d = ACKD_DEFAULT;
    else if (set_suppr) dec_d = ACKD_SUPPR;
    else if (set_pend)  dec_d = ACKD_PEND;
    else if (set_plain) dec_d = ACKD_PLAIN;
  end

  always_comb begin
    send_d = 1'b0;
    pend_d = 1'b0;
    if (frame_end) begin
      case (dec_q)
        ACKD_PLAIN:   send_d = 1'b1;
        ACKD_PEND:    begin send_d = 1'b1; pend_d = 1'b1; end
        ACKD_DEFAULT: send_d = auto_ack_en;
        default:      send_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q        <= ACKD_DEFAULT;
      ack_send     <= 1'b0;
      ack_pend_bit <= 1'b0;
    end else begin
      dec_q        <= dec_d;
      ack_send     <= send_d;
      ack_pend_bit <= pend_d;
    end
  end

  // R8
  suppr_no_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_q == ACKD_SUPPR) && frame_end |=> !ack_send);

  // R6
  pend_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pend_bit |-> ack_send);

endmodule

// File: rtl/exc_flags.sv
module exc_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clear,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_d;

    always_comb begin
      flag_d = flags[i];
      if (clear)  flag_d = 1'b0;
      if (set[i]) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_d;
    end

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !clear |=> flags[i]);
  end

endmodule

// File: rtl/radio_cmd_arbiter.sv
module radio_cmd_arbiter
  import radio_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_valid,
  input  logic [CMD_W-1:0] opcode,
  input  logic             radio_idle,
  input  logic             frame_rx,
  input  logic             auto_ack_en,
  input  logic             frame_end,
  input  logic             exc_clear,
  output logic             osc_off_pulse,
  output logic             flush_rx_pulse,
  output logic             flush_tx_pulse,
  output logic             nack_pulse,
  output logic             ack_send,
  output logic             ack_pend_bit,
  output logic             usage_err,
  output logic             frame_aborted
);

  localparam int NFLAG = 2;

  cmd_hit_t         hit;
  logic             ack_any;
  logic [NFLAG-1:0] flag_set, flag_q;
  logic             osc_d, frx_d, ftx_d, nack_d;

  cmd_decode u_dec (
    .valid  (strobe_valid),
    .opcode (opcode),
    .hit    (hit)
  );

  always_comb begin
    ack_any     = hit.ack | hit.ackp | hit.nack;
    osc_d       = hit.osc & radio_idle;
    frx_d       = hit.frx;
    ftx_d       = hit.ftx;
    nack_d      = hit.nack & frame_rx;
    flag_set[0] = (hit.osc & ~radio_idle) | (ack_any & ~frame_rx);
    flag_set[1] = (hit.osc | hit.frx) & frame_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_off_pulse  <= 1'b0;
      flush_rx_pulse <= 1'b0;
      flush_tx_pulse <= 1'b0;
      nack_pulse     <= 1'b0;
    end else begin
      osc_off_pulse  <= osc_d;
      flush_rx_pulse <= frx_d;
      flush_tx_pulse <= ftx_d;
      nack_pulse     <= nack_d;
    end
  end

  exc_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clear (exc_clear),
    .flags (flag_q)
  );

  assign usage_err     = flag_q[0];
  assign frame_aborted = flag_q[1];

  ack_sched u_ack (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end),
    .auto_ack_en  (auto_ack_en),
    .set_plain    (hit.ack & frame_rx),
    .set_pend     (hit.ackp & frame_rx),
    .set_suppr    (hit.nack & frame_rx),
    .ack_send     (ack_send),
    .ack_pend_bit (ack_pend_bit)
  );

  // R2
  osc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_off_pulse) |-> $past(radio_idle));

  // R4
  frx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_rx_pulse) && $past(frame_rx) |-> frame_aborted);

  // R3
  osc_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_valid && (opcode == OP_OSC_OFF) && !radio_idle |=> usage_err && !osc_off_pulse);

  // R5
  ftx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_valid && (opcode == OP_FLUSH_TX) |=> flush_tx_pulse);

endmodule

// File: tb/radio_cmd_arbiter_bench.sv
module radio_cmd_arbiter_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe_valid, radio_idle, frame_rx, auto_ack_en, frame_end, exc_clear;
  logic [7:0] opcode;
  logic       osc_off_pulse, flush_rx_pulse, flush_tx_pulse, nack_pulse;
  logic       ack_send, ack_pend_bit, usage_err, frame_aborted;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_cmd_arbiter u_radio_cmd_arbiter (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe_valid   (strobe_valid),
    .opcode         (opcode),
    .radio_idle     (radio_idle),
    .frame_rx       (frame_rx),
    .auto_ack_en    (auto_ack_en),
    .frame_end      (frame_end),
    .exc_clear      (exc_clear),
    .osc_off_pulse  (osc_off_pulse),
    .flush_rx_pulse (flush_rx_pulse),
    .flush_tx_pulse (flush_tx_pulse),
    .nack_pulse     (nack_pulse),
    .ack_send       (ack_send),
    .ack_pend_bit   (ack_pend_bit),
    .usage_err      (usage_err),
    .frame_aborted  (frame_aborted)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {osc, flush_rx, flush_tx, nack}
  function automatic logic [3:0] pulses();
    return {osc_off_pulse, flush_rx_pulse, flush_tx_pulse, nack_pulse};
  endfunction

  function automatic logic [1:0] flags();
    return {usage_err, frame_aborted};
  endfunction

  function automatic logic [1:0] ackv();
    return {ack_send, ack_pend_bit};
  endfunction

  // drive a strobe for one cycle, sample after the capturing edge
  task automatic strobe(logic [7:0] op, logic idle, logic frx, logic clr = 1'b0);
    @(negedge clk);
    strobe_valid = 1'b1; opcode = op; radio_idle = idle; frame_rx = frx; exc_clear = clr;
    @(posedge clk);
    @(negedge clk);
    strobe_valid = 1'b0; exc_clear = 1'b0;
  endtask

  task automatic end_frame(logic auto);
    @(negedge clk);
    frame_end = 1'b1; auto_ack_en = auto;
    @(posedge clk);
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    exc_clear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exc_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pulses", 8'(pulses()), 8'h0);
    check("R1 flags",  8'(flags()),  8'h0);
    check("R1 ack",    8'(ackv()),   8'h0);
  endtask

  task automatic t_osc_idle();
    strobe(8'h01, 1'b1, 1'b0);
    check("R2 osc pulse", 8'(pulses()), 8'h8);
    check("R2 no flag",   8'(flags()),  8'h0);
    @(negedge clk);
    check("R2 one cycle", 8'(pulses()), 8'h0);
  endtask

  task automatic t_osc_busy();
    strobe(8'h01, 1'b0, 1'b1);
    check("R3 no pulse with frame", 8'(pulses()), 8'h0);
    check("R3 both flags",          8'(flags()),  8'h3);
    clear_flags();
    strobe(8'h01, 1'b0, 1'b0);
    check("R3 no pulse busy", 8'(pulses()), 8'h0);
    check("R3 usage only",    8'(flags()),  8'h2);
    clear_flags();
  endtask

  task automatic t_flush_rx();
    strobe(8'h02, 1'b1, 1'b0);
    check("R4 pulse no frame", 8'(pulses()), 8'h4);
    check("R4 no abort",       8'(flags()),  8'h0);
    strobe(8'h02, 1'b0, 1'b1);
    check("R4 pulse in frame", 8'(pulses()), 8'h4);
    check("R4 abort",          8'(flags()),  8'h1);
    clear_flags();
    check("R4 cleared", 8'(flags()), 8'h0);
  endtask

  task automatic t_flush_tx();
    strobe(8'h03, 1'b0, 1'b1);
    check("R5 tx pulse", 8'(pulses()), 8'h2);
    check("R5 no flag",  8'(flags()),  8'h0);
  endtask

  task automatic t_ack();
    strobe(8'h04, 1'b0, 1'b1);
    end_frame(1'b0);
    check("R6 plain ack", 8'(ackv()), 8'h2);
    @(negedge clk);
    check("R6 one cycle", 8'(ackv()), 8'h0);
    strobe(8'h05, 1'b0, 1'b1);
    end_frame(1'b0);
    check("R6 pending ack", 8'(ackv()), 8'h3);
  endtask

  task automatic t_override();
    strobe(8'h04, 1'b0, 1'b1);
    strobe(8'h05, 1'b0, 1'b1);
    end_frame(1'b0);
    check("R7 plain then pend", 8'(ackv()), 8'h3);
    strobe(8'h05, 1'b0, 1'b1);
    strobe(8'h04, 1'b0, 1'b1);
    end_frame(1'b0);
    check("R7 pend then plain", 8'(ackv()), 8'h2);
    strobe(8'h04, 1'b0, 1'b1);
    strobe(8'h06, 1'b0, 1'b1);
    end_frame(1'b1);
    check("R7 ack then nack", 8'(ackv()), 8'h0);
    strobe(8'h06, 1'b0, 1'b1);
    strobe(8'h05, 1'b0, 1'b1);
    end_frame(1'b0);
    check("R7 nack then pend", 8'(ackv()), 8'h3);
  endtask

  task automatic t_nack();
    strobe(8'h06, 1'b0, 1'b1);
    check("R8 nack pulse", 8'(pulses()), 8'h1);
    end_frame(1'b1);
    check("R8 suppressed", 8'(ackv()), 8'h0);
    check("R8 no flag",    8'(flags()), 8'h0);
  endtask

  task automatic t_auto();
    end_frame(1'b1);
    check("R9 auto ack", 8'(ackv()), 8'h2);
    end_frame(1'b0);
    check("R9 no auto", 8'(ackv()), 8'h0);
  endtask

  task automatic t_ack_noframe();
    strobe(8'h05, 1'b1, 1'b0);
    check("R10 usage", 8'(flags()), 8'h2);
    end_frame(1'b0);
    check("R10 no send", 8'(ackv()), 8'h0);
    clear_flags();
    strobe(8'h06, 1'b1, 1'b0);
    check("R10 no nack pulse", 8'(pulses()), 8'h0);
    check("R10 nack usage",    8'(flags()),  8'h2);
    end_frame(1'b1);
    check("R10 default kept", 8'(ackv()), 8'h2);
    clear_flags();
  endtask

  task automatic t_sticky();
    strobe(8'h04, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    check("R11 held", 8'(flags()), 8'h2);
    clear_flags();
    check("R11 cleared", 8'(flags()), 8'h0);
    strobe(8'h02, 1'b0, 1'b1, 1'b1);
    check("R11 set beats clear", 8'(flags()), 8'h1);
    clear_flags();
  endtask

  task automatic t_unknown();
    strobe(8'hA5, 1'b0, 1'b1);
    check("R12 no pulse", 8'(pulses()), 8'h0);
    check("R12 no flag",  8'(flags()),  8'h0);
    strobe(8'h00, 1'b0, 1'b1);
    end_frame(1'b0);
    check("R12 no ack", 8'(ackv()), 8'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    strobe_valid = 1'b0; opcode = 8'h00; radio_idle = 1'b1; frame_rx = 1'b0;
    auto_ack_en = 1'b0; frame_end = 1'b0; exc_clear = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_osc_idle();
    t_osc_busy();
    t_flush_rx();
    t_flush_tx();
    t_ack();
    t_override();
    t_nack();
    t_auto();
    t_ack_noframe();
    t_sticky();
    t_unknown();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule